// File: doc/BRIEF.md
# Pixel Clock PLL Programming Sequencer

This block sets up a pixel-clock PLL for a display pipeline. When it gets a start pulse, it captures the requested active width and height. It looks that resolution up in a built-in table of ten display modes. If no mode matches both sizes exactly, it uses a 25 MHz fallback. The lookup yields two configuration words. The high word is presented first, then the block walks the PLL control register through a fixed release order.

The release order is as follows. The outer bypass is dropped first. Next comes a value with only the inner-bypass and power-on bits set, followed by the selected low configuration word. After that, power-on, inner bypass and outer bypass are changed one at a time, and a programmable number of clock cycles separates each of these three changes. A fixed wait stands in for lock detection. The block also presents a general PLL control word: power on, not bypassed, first input selected, all divider fields zero. A busy flag covers the whole run, and a one-cycle done pulse marks the final write.

Top module: `pxclk_pll_seq`

## Requirements
- R1: Each table resolution maps to a rate r: 800x600=40, 1024x768=65, 1152x864=80, 1280x768=80, 1280x720=74, 1280x960=108, 1280x1024=108, 1600x1200=162, 1920x1080=148, 1920x1200=193. The low word is r in bits [7:0], 1 in bits [14:8], and bits 17 and 18 set. The high word is r in bits [11:4] with bit 0 set.
- R2: Any width/height pair that is not an exact match for one entry, including a pair where only one size matches, gives the words for r=25.
- R3: After the clock edge that accepts a start, `cfg_hi` and `cfg_lo` hold the selected words and `busy` is high, while `pll_ctl` still holds its old value. Changes of `h_act`/`v_act` without an accepted start leave both words unchanged.
- R4: On the next three edges, `pll_ctl` changes in this order: it first drops bit 31 (outer bypass), then becomes 0x0006_0000 (only bit 18 inner bypass and bit 17 power-on set), then takes the low word. Outside a run, `pll_ctl` stays unchanged.
- R5: The low word stays on `pll_ctl` for exactly WAIT_CYCLES cycles. After that, bit 17 is cleared.
- R6: After a further WAIT_CYCLES cycles, bit 18 is cleared. After another WAIT_CYCLES cycles, bit 31 is set.
- R7: `done` is high for exactly one cycle, aligned with the write that sets bit 31. `busy` falls on that same edge, and `busy` only rises in response to a start.
- R8: A start that arrives while `busy` is high is ignored: neither the words nor the sequence timing change.
- R9: `gen_ctl` reads 0x0000_2000 from the first accepted start onward: bit 13 (power) set, bypass, input select and all divider fields zero.
- R10: After reset, `pll_ctl` = 0x8000_0000, `cfg_lo` = `cfg_hi` = `gen_ctl` = 0, and `busy` = `done` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, accepted only while idle |
| h_act | input | DIM_W | Requested active width in pixels |
| v_act | input | DIM_W | Requested active height in lines |
| cfg_lo | output | 32 | Selected low configuration word |
| cfg_hi | output | 32 | Selected high configuration word |
| gen_ctl | output | 32 | General PLL control word |
| pll_ctl | output | 32 | Live PLL control register value |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse on the final write |

## Verification
On every cycle, the assertions check the following properties:
- `done` and `busy` are mutually exclusive, and `done` lasts one cycle.
- `busy` only rises after a start.
- Starts that arrive while busy leave the words untouched.
- `pll_ctl` stays quiet while idle.
- The final write sets outer bypass.
- The general word is correct throughout a run.

Other properties can only be shown by the directed scenarios:
- the table contents and the fallback;
- the exact order of the intermediate register values;
- the exact length of each wait;
- the timing of the sequence when a start is injected mid-run.

// File: rtl/pxclk_pll_pkg.sv
package pxclk_pll_pkg;
  localparam int CTL_W        = 32;
  localparam int TBL_DIM_W    = 12;
  localparam int RATE_W       = 8;
  localparam int N_MODES      = 10;
  localparam int OUTER_BYP_B  = 31;
  localparam int INNER_BYP_B  = 18;
  localparam int PWR_ON_B     = 17;
  localparam int GEN_PWR_B    = 13;
  localparam logic [RATE_W-1:0] FALLBACK_RATE = 8'd25;

  typedef struct packed {
    logic [TBL_DIM_W-1:0] h;
    logic [TBL_DIM_W-1:0] v;
    logic [RATE_W-1:0]    rate;
  } mode_ent_t;

  function automatic mode_ent_t mode_entry(input int idx);
    mode_ent_t e;
    case (idx)
      0:       e = '{12'd800,  12'd600,  8'd40};
      1:       e = '{12'd1024, 12'd768,  8'd65};
      2:       e = '{12'd1152, 12'd864,  8'd80};
      3:       e = '{12'd1280, 12'd768,  8'd80};
      4:       e = '{12'd1280, 12'd720,  8'd74};
      5:       e = '{12'd1280, 12'd960,  8'd108};
      6:       e = '{12'd1280, 12'd1024, 8'd108};
      7:       e = '{12'd1600, 12'd1200, 8'd162};
      8:       e = '{12'd1920, 12'd1080, 8'd148};
      default: e = '{12'd1920, 12'd1200, 8'd193};
    endcase
    return e;
  endfunction

  function automatic logic [CTL_W-1:0] lo_word(input logic [RATE_W-1:0] r);
    logic [CTL_W-1:0] w;
    w = '0;
    w[7:0] = r;
    w[14:8] = 7'd1;
    w[INNER_BYP_B] = 1'b1;
    w[PWR_ON_B] = 1'b1;
    return w;
  endfunction

  function automatic logic [CTL_W-1:0] hi_word(input logic [RATE_W-1:0] r);
    logic [CTL_W-1:0] w;
    w = '0;
    w[11:4] = r;
    w[0] = 1'b1;
    return w;
  endfunction

  function automatic logic [CTL_W-1:0] gen_word();
    logic [CTL_W-1:0] w;
    w = '0;
    w[GEN_PWR_B] = 1'b1;
    return w;
  endfunction
endpackage

// File: rtl/pxclk_mode_lut.sv
module pxclk_mode_lut
  import pxclk_pll_pkg::*;
#(
  parameter int DIM_W = 12
) (
  input  logic [DIM_W-1:0] h_act,
  input  logic [DIM_W-1:0] v_act,
  output logic [CTL_W-1:0] lut_lo,
  output logic [CTL_W-1:0] lut_hi
);
  logic [N_MODES-1:0] hit;

  for (genvar g = 0; g < N_MODES; g++) begin : g_match
    localparam mode_ent_t ENT = mode_entry(g);
    assign hit[g] = (h_act == DIM_W'(ENT.h)) && (v_act == DIM_W'(ENT.v));
  end

  logic [RATE_W-1:0] rate_sel;

  always_comb begin
    rate_sel = FALLBACK_RATE;
    for (int i = N_MODES - 1; i >= 0; i--) begin
      if (hit[i]) rate_sel = mode_entry(i).rate;
    end
  end

  assign lut_lo = lo_word(rate_sel);
  assign lut_hi = hi_word(rate_sel);
endmodule

// File: rtl/pxclk_wait_timer.sv
module pxclk_wait_timer #(
  parameter int WAIT_CYCLES = 150000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expire
);
  localparam int CNT_W = $clog2(WAIT_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WAIT_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  assign expire = run && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run || expire) cnt <= '0;
    else                       cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pxclk_seq_fsm.sv
module pxclk_seq_fsm
  import pxclk_pll_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CTL_W-1:0] lut_lo,
  input  logic [CTL_W-1:0] lut_hi,
  input  logic             expire,
  output logic             tmr_run,
  output logic [CTL_W-1:0] cfg_lo,
  output logic [CTL_W-1:0] cfg_hi,
  output logic [CTL_W-1:0] gen_ctl,
  output logic [CTL_W-1:0] pll_ctl,
  output logic             busy,
  output logic             done
);
  typedef enum logic [2:0] {
    ST_IDLE, ST_DROP_OB, ST_ARM, ST_LOAD, ST_HOLD_CFG, ST_HOLD_PWR, ST_HOLD_IB
  } st_t;

  st_t st;

  assign tmr_run = (st == ST_HOLD_CFG) || (st == ST_HOLD_PWR) || (st == ST_HOLD_IB);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      cfg_lo  <= '0;
      cfg_hi  <= '0;
      gen_ctl <= '0;
      pll_ctl <= CTL_W'(1) << OUTER_BYP_B;
      busy    <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          cfg_lo  <= lut_lo;
          cfg_hi  <= lut_hi;
          gen_ctl <= gen_word();
          busy    <= 1'b1;
          st      <= ST_DROP_OB;
        end
        ST_DROP_OB: begin
          pll_ctl[OUTER_BYP_B] <= 1'b0;
          st <= ST_ARM;
        end
        ST_ARM: begin
          pll_ctl <= (CTL_W'(1) << INNER_BYP_B) | (CTL_W'(1) << PWR_ON_B);
          st <= ST_LOAD;
        end
        ST_LOAD: begin
          pll_ctl <= cfg_lo;
          st <= ST_HOLD_CFG;
        end
        ST_HOLD_CFG: if (expire) begin
          pll_ctl[PWR_ON_B] <= 1'b0;
          st <= ST_HOLD_PWR;
        end
        ST_HOLD_PWR: if (expire) begin
          pll_ctl[INNER_BYP_B] <= 1'b0;
          st <= ST_HOLD_IB;
        end
        ST_HOLD_IB: if (expire) begin
          pll_ctl[OUTER_BYP_B] <= 1'b1;
          done <= 1'b1;
          busy <= 1'b0;
          st   <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pxclk_pll_seq.sv
module pxclk_pll_seq
  import pxclk_pll_pkg::*;
#(
  parameter int DIM_W       = 12,
  parameter int WAIT_CYCLES = 150000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [DIM_W-1:0] h_act,
  input  logic [DIM_W-1:0] v_act,
  output logic [CTL_W-1:0] cfg_lo,
  output logic [CTL_W-1:0] cfg_hi,
  output logic [CTL_W-1:0] gen_ctl,
  output logic [CTL_W-1:0] pll_ctl,
  output logic             busy,
  output logic             done
);
  logic [CTL_W-1:0] lut_lo, lut_hi;
  logic             tmr_run, expire;

  pxclk_mode_lut #(.DIM_W(DIM_W)) lut_i (
    .h_act(h_act), .v_act(v_act), .lut_lo(lut_lo), .lut_hi(lut_hi)
  );

  pxclk_wait_timer #(.WAIT_CYCLES(WAIT_CYCLES)) tmr_i (
    .clk(clk), .rst(rst), .run(tmr_run), .expire(expire)
  );

  pxclk_seq_fsm fsm_i (
    .clk(clk), .rst(rst), .start(start), .lut_lo(lut_lo), .lut_hi(lut_hi),
    .expire(expire), .tmr_run(tmr_run), .cfg_lo(cfg_lo), .cfg_hi(cfg_hi),
    .gen_ctl(gen_ctl), .pll_ctl(pll_ctl), .busy(busy), .done(done)
  );
endmodule

// File: rtl/pxclk_pll_seq_chk.sv
module pxclk_pll_seq_chk
  import pxclk_pll_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic [CTL_W-1:0] cfg_lo,
  input logic [CTL_W-1:0] cfg_hi,
  input logic [CTL_W-1:0] gen_ctl,
  input logic [CTL_W-1:0] pll_ctl,
  input logic             busy,
  input logic             done
);
  assert_done_excl_busy_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_busy_needs_start_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));
  assert_ignore_busy_start_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> ($stable(cfg_lo) && $stable(cfg_hi)));
  assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(pll_ctl));
  assert_final_outer_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> pll_ctl[OUTER_BYP_B]);
  assert_gen_word_R9: assert property (@(posedge clk) disable iff (rst)
    busy |-> (gen_ctl == 32'h0000_2000));
endmodule

bind pxclk_pll_seq pxclk_pll_seq_chk chk_i (
  .clk(clk), .rst(rst), .start(start), .cfg_lo(cfg_lo), .cfg_hi(cfg_hi),
  .gen_ctl(gen_ctl), .pll_ctl(pll_ctl), .busy(busy), .done(done)
);

// File: tb/pxclk_pll_seq_tb.sv
module pxclk_pll_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W = 5;
  localparam logic [31:0] OB = 32'h8000_0000;
  localparam logic [31:0] IB = 32'h0004_0000;
  localparam logic [31:0] PO = 32'h0002_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [11:0] h_act = '0, v_act = '0;
  logic [31:0] cfg_lo, cfg_hi, gen_ctl, pll_ctl;
  logic busy, done;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pxclk_pll_seq #(.DIM_W(12), .WAIT_CYCLES(W)) dut_i (
    .clk(clk), .rst(rst), .start(start), .h_act(h_act), .v_act(v_act),
    .cfg_lo(cfg_lo), .cfg_hi(cfg_hi), .gen_ctl(gen_ctl), .pll_ctl(pll_ctl),
    .busy(busy), .done(done)
  );

  function automatic logic [31:0] exp_lo(input int r);
    return 32'(r) | 32'h100 | IB | PO;
  endfunction
  function automatic logic [31:0] exp_hi(input int r);
    return (32'(r) << 4) | 32'h1;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    chk("R10 pll_ctl", pll_ctl, 32'h8000_0000);
    chk("R10 cfg_lo", cfg_lo, 0);
    chk("R10 cfg_hi", cfg_hi, 0);
    chk("R10 gen_ctl", gen_ctl, 0);
    chk("R10 busy", 32'(busy), 0);
    chk("R10 done", 32'(done), 0);
  endtask

  task automatic run_mode(input int h, input int v, input int r, input bit poke, input string req);
    logic [31:0] prev, lo;
    lo = exp_lo(r);
    prev = pll_ctl;
    h_act = 12'(h); v_act = 12'(v); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk({req, " R3 cfg_hi"}, cfg_hi, exp_hi(r));
    chk({req, " R3 cfg_lo"}, cfg_lo, lo);
    chk("R9 gen_ctl", gen_ctl, 32'h0000_2000);
    chk("R3 busy", 32'(busy), 1);
    chk("R3 pll_ctl unchanged", pll_ctl, prev);
    @(negedge clk); chk("R4 drop outer", pll_ctl, prev & ~OB);
    @(negedge clk); chk("R4 arm", pll_ctl, 32'h0006_0000);
    @(negedge clk); chk("R4 load", pll_ctl, lo);
    if (poke) begin
      h_act = 12'd1920; v_act = 12'd1200; start = 1'b1;
      @(negedge clk); start = 1'b0;
      chk("R8 cfg_hi kept", cfg_hi, exp_hi(r));
      chk("R8 cfg_lo kept", cfg_lo, lo);
      repeat (W - 2) @(negedge clk);
    end else repeat (W - 1) @(negedge clk);
    chk("R5 hold cfg", pll_ctl, lo);
    @(negedge clk); chk("R5 power off", pll_ctl, lo & ~PO);
    repeat (W - 1) @(negedge clk); chk("R6 hold pwr", pll_ctl, lo & ~PO);
    chk("R7 no early done", 32'(done), 0);
    @(negedge clk); chk("R6 inner off", pll_ctl, lo & ~PO & ~IB);
    repeat (W - 1) @(negedge clk); chk("R6 hold ib", pll_ctl, lo & ~PO & ~IB);
    @(negedge clk); chk("R6 outer on", pll_ctl, (lo & ~PO & ~IB) | OB);
    chk("R7 done", 32'(done), 1);
    chk("R7 busy low", 32'(busy), 0);
    @(negedge clk); chk("R7 done one cycle", 32'(done), 0);
    chk("R4 idle stable", pll_ctl, (lo & ~PO & ~IB) | OB);
  endtask

  task automatic t_table();
    int hs[10] = '{800, 1024, 1152, 1280, 1280, 1280, 1280, 1600, 1920, 1920};
    int vs[10] = '{600, 768, 864, 768, 720, 960, 1024, 1200, 1080, 1200};
    int rs[10] = '{40, 65, 80, 80, 74, 108, 108, 162, 148, 193};
    for (int i = 0; i < 10; i++) run_mode(hs[i], vs[i], rs[i], 1'b0, "R1");
  endtask

  task automatic t_fallback();
    run_mode(1280, 800, 25, 1'b0, "R2 unknown");
    run_mode(800, 601, 25, 1'b0, "R2 partial");
  endtask

  task automatic t_idle_inputs();
    logic [31:0] hi0;
    hi0 = cfg_hi;
    h_act = 12'd1024; v_act = 12'd768;
    repeat (3) @(negedge clk);
    chk("R3 idle cfg_hi", cfg_hi, hi0);
    chk("R3 idle busy", 32'(busy), 0);
  endtask

  task automatic t_busy_start();
    run_mode(1600, 1200, 162, 1'b1, "R8");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_table();
    t_fallback();
    t_idle_inputs();
    t_busy_start();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule